// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block decides whether the flash array may enter a program or erase operation. Software writes a small set of control words: a control word with a write-enable bit and four operation request bits, two halves of a per-block erase permission mask, and an emulation-active bit. From these the block picks one active mode: idle, program, erase, program-verify or erase-verify. It also produces a per-block erase strobe mask for the array.

An error-detect input represents every source of runaway or sequence violation. If it fires during program or erase, the operation is dropped in the same clock edge. A sticky error flag is then raised. From that point until reset, program and erase cannot be entered again, but both verify modes stay reachable. The abort does not touch the stored control words. Only reset clears the flag and the control words. After reset the block is fully protected.

Top module: `flash_guard_ctrl`

## Requirements
- R1: After reset, mode is idle (0), the erase strobe mask is all zeros and the error flag is 0. All control words read as zero, so program and erase stay blocked until software sets them up.
- R2: Writes use `wr_sel`: 0 selects the control word, 1 the low half of the erase mask (blocks 0..DATA_W-1), 2 the high half (blocks DATA_W..2*DATA_W-1), and 3 the emulation bit (`wr_data[0]`). Control word bits are: bit 0 write-enable, bit 1 program request, bit 2 erase request, bit 3 program-verify request, bit 4 erase-verify request.
- R3: `mode` is encoded as 0 idle, 1 program, 2 erase, 3 program-verify, 4 erase-verify. It is registered, and it reflects the stored control words one clock edge after they are updated.
- R4: When the write-enable bit is 0, a program or erase request leaves the mode at idle.
- R5: When the emulation bit is 1, both program and erase requests leave the mode at idle, whatever the other settings are.
- R6: An erase request enters erase mode only if at least one bit of the combined erase mask is set. The mask does not restrict program requests.
- R7: If more than one of the four request bits is set, or none is, the mode is idle.
- R8: `erase_strobe` equals the combined erase mask ANDed with `blk_sel` while the mode is erase, and is all zeros in every other mode.
- R9: If `err_in` is high at a clock edge while the mode is program or erase, that same edge sets the error flag and returns the mode to idle. The flag then stays at 1 until reset.
- R10: While the error flag is set, program and erase requests leave the mode at idle. Program-verify and erase-verify requests still enter their verify modes.
- R11: `err_in` has no effect while the mode is idle, program-verify or erase-verify.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | DATA_W | Write data |
| err_in | input | 1 | Error-detect input |
| blk_sel | input | 2*DATA_W | One bit per block selected by the array address decode |
| mode | output | 3 | Active mode code |
| erase_strobe | output | 2*DATA_W | Per-block erase strobe mask |
| err_flag | output | 1 | Sticky error-protection flag |

## Verification
The assertions assume that `err_in` and `blk_sel` are ordinary synchronous inputs. They also assume the register writes are single-cycle strobes, so any request held in the control word is re-evaluated on every edge.

The stimulus changes every input only on the falling edge. It leaves `err_in` low across the whole protection sweep, so that the expected mode depends only on the stored words. It raises `err_in` for exactly one cycle, and only in the error scenarios, where the mode at that edge is known in advance.

// File: rtl/flash_guard_pkg.sv
// Shared encodings for the flash protection controller.
// Assumes: control word is at least 5 bits wide.
package flash_guard_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE  = 3'd0,
        MODE_PROG  = 3'd1,
        MODE_ERASE = 3'd2,
        MODE_PVFY  = 3'd3,
        MODE_EVFY  = 3'd4
    } fg_mode_e;

    localparam int CTL_W     = 5;
    localparam int CTL_WREN  = 0;
    localparam int CTL_PROG  = 1;
    localparam int CTL_ERASE = 2;
    localparam int CTL_PVFY  = 3;
    localparam int CTL_EVFY  = 4;

    localparam logic [1:0] SEL_CTRL    = 2'd0;
    localparam logic [1:0] SEL_MASK_LO = 2'd1;
    localparam logic [1:0] SEL_MASK_HI = 2'd2;
    localparam logic [1:0] SEL_EMU     = 2'd3;

endpackage

// File: rtl/fg_regs.sv
// Software-visible control storage: control word, two erase mask halves,
// emulation bit. Assumes single-cycle write strobes and DATA_W >= CTL_W.
module fg_regs
    import flash_guard_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int NBLK = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CTL_W-1:0]  ctrl_q,
    output logic [NBLK-1:0]   mask_q,
    output logic              emu_q
);

    // Capture a write into the selected word; reset leaves everything protected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            emu_q  <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL:    ctrl_q <= wr_data[CTL_W-1:0];
                SEL_MASK_LO: mask_q[DATA_W-1:0] <= wr_data;
                SEL_MASK_HI: mask_q[NBLK-1:DATA_W] <= wr_data;
                default:     emu_q <= wr_data[0];
            endcase
        end
    end

endmodule

// File: rtl/fg_mode.sv
// Mode selection and error latch. Each edge re-evaluates the stored words.
// Program and erase are entered only when every protection layer allows it.
// An error seen in program or erase aborts to idle and latches a sticky flag.
// Assumes: err_in synchronous to clk.
module fg_mode
    import flash_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctrl,
    input  logic             mask_any,
    input  logic             emu,
    input  logic             err_in,
    output fg_mode_e         mode_q,
    output logic             err_q
);

    logic     busy;
    logic     err_hit;
    logic     pe_ok;
    logic     single;
    fg_mode_e mode_d;

    // Decide the next mode from the stored words and the protection state.
    always_comb begin
        busy    = (mode_q == MODE_PROG) || (mode_q == MODE_ERASE);
        err_hit = busy && err_in;
        pe_ok   = ctrl[CTL_WREN] && !emu && !err_q && !err_hit;
        single  = $onehot(ctrl[CTL_EVFY:CTL_PROG]);
        mode_d  = MODE_IDLE;
        if (single) begin
            if (ctrl[CTL_PROG] && pe_ok)
                mode_d = MODE_PROG;
            else if (ctrl[CTL_ERASE] && pe_ok && mask_any)
                mode_d = MODE_ERASE;
            else if (ctrl[CTL_PVFY])
                mode_d = MODE_PVFY;
            else if (ctrl[CTL_EVFY])
                mode_d = MODE_EVFY;
        end
    end

    // Register the mode and hold the error flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_IDLE;
            err_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            err_q  <= err_q | err_hit;
        end
    end

endmodule

// File: rtl/fg_strobe.sv
// Per-block erase strobe: a block strobes only in erase mode, when it is
// selected by the array and permitted by the mask. Purely combinational.
module fg_strobe #(
    parameter int NBLK = 16
) (
    input  logic            erase_act,
    input  logic [NBLK-1:0] mask,
    input  logic [NBLK-1:0] blk_sel,
    output logic [NBLK-1:0] strobe
);

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        // Gate one block's strobe by mode, permission and selection.
        assign strobe[i] = erase_act & mask[i] & blk_sel[i];
    end

endmodule

// File: rtl/flash_guard_ctrl.sv
// Top of the flash program/erase protection controller.
// Ties the control storage, the mode/error logic and the strobe gating together.
// Assumes: synchronous active-low reset, single-cycle writes.
module flash_guard_ctrl
    import flash_guard_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int NBLK = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              err_in,
    input  logic [NBLK-1:0]   blk_sel,
    output logic [2:0]        mode,
    output logic [NBLK-1:0]   erase_strobe,
    output logic              err_flag
);

    logic [CTL_W-1:0] ctrl_q;
    logic [NBLK-1:0]  mask_q;
    logic             emu_q;
    fg_mode_e         mode_q;
    logic             err_q;

    fg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .mask_q  (mask_q),
        .emu_q   (emu_q)
    );

    fg_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl_q),
        .mask_any (|mask_q),
        .emu      (emu_q),
        .err_in   (err_in),
        .mode_q   (mode_q),
        .err_q    (err_q)
    );

    fg_strobe #(.NBLK(NBLK)) u_strobe (
        .erase_act (mode_q == MODE_ERASE),
        .mask      (mask_q),
        .blk_sel   (blk_sel),
        .strobe    (erase_strobe)
    );

    // Drive the mode code and the error flag onto the ports.
    assign mode     = mode_q;
    assign err_flag = err_q;

endmodule

// File: rtl/fg_guard_checker.sv
// Property checker for flash_guard_ctrl. It observes the ports and the stored
// control words, and is attached to every instance of the top by a bind.
module fg_guard_checker
    import flash_guard_pkg::*;
#(
    parameter int NBLK = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_in,
    input logic [NBLK-1:0]  blk_sel,
    input logic [2:0]       mode,
    input logic [NBLK-1:0]  erase_strobe,
    input logic             err_flag,
    input logic [CTL_W-1:0] ctrl_q,
    input logic [NBLK-1:0]  mask_q,
    input logic             emu_q
);

    logic busy;
    assign busy = (mode == MODE_PROG) || (mode == MODE_ERASE);

    assert_no_pe_without_wren_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTL_WREN] |=> !busy);

    assert_emulation_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        emu_q |=> !busy);

    assert_erase_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> (mode != MODE_ERASE));

    assert_multi_request_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ctrl_q[CTL_EVFY:CTL_PROG]) > 1) |=> (mode == MODE_IDLE));

    assert_strobe_off_outside_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_ERASE) |-> (erase_strobe == '0));

    assert_strobe_within_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((erase_strobe & ~(blk_sel & mask_q)) == '0));

    assert_abort_on_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && err_in) |=> (err_flag && mode == MODE_IDLE));

    assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_no_reentry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !busy);

    assert_error_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && !busy) |=> !err_flag);

endmodule

bind flash_guard_ctrl fg_guard_checker #(.NBLK(NBLK)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_in       (err_in),
    .blk_sel      (blk_sel),
    .mode         (mode),
    .erase_strobe (erase_strobe),
    .err_flag     (err_flag),
    .ctrl_q       (ctrl_q),
    .mask_q       (mask_q),
    .emu_q        (emu_q)
);

// File: tb/sim_flash_guard_ctrl.sv
`timescale 1ns/1ps
module sim_flash_guard_ctrl;

    localparam int DW = 8;
    localparam int NB = 2 * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic          err_in = 1'b0;
    logic [NB-1:0] blk_sel = '0;
    logic [2:0]    mode;
    logic [NB-1:0] erase_strobe;
    logic          err_flag;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    flash_guard_ctrl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .err_in(err_in), .blk_sel(blk_sel),
        .mode(mode), .erase_strobe(erase_strobe), .err_flag(err_flag)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One more edge so the mode follows the stored words.
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_err();
        @(negedge clk);
        err_in = 1'b1;
        @(negedge clk);
        err_in = 1'b0;
    endtask

    // Expected mode from the requirements (R4..R7, R10).
    function automatic logic [2:0] exp_mode(input logic [4:0] c, input logic emu,
                                            input logic [NB-1:0] m, input logic err);
        logic ok;
        ok = c[0] && !emu && !err;
        if ($countones(c[4:1]) != 1) return 3'd0;
        if (c[1]) return ok ? 3'd1 : 3'd0;
        if (c[2]) return (ok && m != '0) ? 3'd2 : 3'd0;
        if (c[3]) return 3'd3;
        return 3'd4;
    endfunction

    initial begin
        do_reset();
        settle();
        // R1: reset state
        chk("R1 mode", {29'd0, mode}, 0);
        chk("R1 strobe", {16'd0, erase_strobe}, 0);
        chk("R1 err", {31'd0, err_flag}, 0);
        wr(2'd0, 8'h02); settle();
        chk("R1 cleared words block program", {29'd0, mode}, 0);

        // Sweep: every control word x emulation x mask pattern (R2..R8)
        for (int e = 0; e < 2; e++) begin
            for (int mp = 0; mp < 3; mp++) begin
                for (int c = 0; c < 32; c++) begin
                    logic [NB-1:0] m;
                    logic [2:0] em;
                    m = (mp == 0) ? '0 : (mp == 1) ? 16'h005A : 16'hC300;
                    blk_sel = 16'hF0F0 ^ NB'(c * 16'h1111) ^ NB'(mp);
                    wr(2'd0, 8'h00);
                    wr(2'd3, DW'(e));
                    wr(2'd1, m[DW-1:0]);
                    wr(2'd2, m[NB-1:DW]);
                    wr(2'd0, DW'(c));
                    settle();
                    em = exp_mode(5'(c), e[0], m, 1'b0);
                    chk("R3/R4/R5/R6/R7 mode", {29'd0, mode}, {29'd0, em});
                    chk("R8 strobe", {16'd0, erase_strobe},
                        {16'd0, (em == 3'd2) ? (m & blk_sel) : 16'd0});
                end
            end
        end

        // R8: strobe tracks blk_sel combinationally in erase mode
        wr(2'd3, 8'h00); wr(2'd1, 8'hFF); wr(2'd2, 8'h81); wr(2'd0, 8'h05); settle();
        for (int b = 0; b < NB; b++) begin
            blk_sel = NB'(1) << b;
            #1;
            chk("R8 single block", {16'd0, erase_strobe},
                {16'd0, blk_sel & 16'h81FF});
        end

        // R9/R10: error in program mode
        do_reset();
        wr(2'd0, 8'h03); settle();
        chk("R9 entered program", {29'd0, mode}, 1);
        pulse_err();
        chk("R9 abort mode", {29'd0, mode}, 0);
        chk("R9 flag set", {31'd0, err_flag}, 1);
        repeat (20) @(negedge clk);
        chk("R9 flag sticky", {31'd0, err_flag}, 1);
        wr(2'd0, 8'h03); settle();
        chk("R10 program blocked", {29'd0, mode}, 0);
        wr(2'd1, 8'h0F); wr(2'd0, 8'h05); settle();
        chk("R10 erase blocked", {29'd0, mode}, 0);
        wr(2'd0, 8'h09); settle();
        chk("R10 program-verify allowed", {29'd0, mode}, 3);
        wr(2'd0, 8'h11); settle();
        chk("R10 erase-verify allowed", {29'd0, mode}, 4);
        do_reset(); settle();
        chk("R1 reset clears flag", {31'd0, err_flag}, 0);

        // R9: error in erase mode
        blk_sel = '1;
        wr(2'd2, 8'h10); wr(2'd0, 8'h05); settle();
        chk("R9 entered erase", {29'd0, mode}, 2);
        chk("R8 erase strobe", {16'd0, erase_strobe}, 32'h1000);
        pulse_err();
        chk("R9 erase abort", {29'd0, mode}, 0);
        chk("R9 erase flag", {31'd0, err_flag}, 1);
        chk("R8 strobe after abort", {16'd0, erase_strobe}, 0);

        // R11: err_in ignored in idle and verify modes
        do_reset(); settle();
        pulse_err(); settle();
        chk("R11 idle ignores error", {31'd0, err_flag}, 0);
        wr(2'd0, 8'h08); settle();
        pulse_err(); settle();
        chk("R11 program-verify ignores error", {31'd0, err_flag}, 0);
        wr(2'd0, 8'h10); settle();
        pulse_err(); settle();
        chk("R11 erase-verify ignores error", {31'd0, err_flag}, 0);
        wr(2'd0, 8'h03); settle();
        chk("R11 program still available", {29'd0, mode}, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule